// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a synchronous host and an asynchronous byte-wide static memory with a 13-bit address, an 8-bit data bus and active-low chip-enable, write-enable and output-enable strobes. The host offers one access at a time on a request/ready handshake. The access carries an address, write data and a read/write flag. For a read, the block returns the byte with a one-cycle valid pulse.

Every strobe phase lasts a number of clock cycles. The block computes each count from a clock-period parameter and the memory's minimum-time limits. The count is the ceiling of the required nanoseconds divided by the period, and is never less than one cycle. At the default 5 ns period, this gives:

- a read window of 30 cycles;
- a write pulse of 20 cycles;
- one data-hold cycle after the write pulse;
- a recovery gap of 9 cycles after a write and 2 cycles after a read.

Writes always finish on write-enable rising while chip-enable is still low. Output-enable stays high for the whole write. The data bus is driven only from the start of the write pulse until one cycle after write-enable rises.

Top module: `sram_seq_ctrl`

## Requirements
- R1: During and straight after reset, req_ready is 1, mem_ce_n, mem_we_n and mem_oe_n are 1, mem_dq_oe is 0 and rsp_valid is 0.
- R2: A read holds mem_ce_n and mem_oe_n low and mem_we_n high for exactly N_RD = max(ceil(150/T), 1) cycles, where T is the clock period in ns.
- R3: A read captures mem_dq_i on the last cycle of its window. It presents that byte on rsp_rdata with rsp_valid high for exactly one cycle, in the cycle right after mem_oe_n rises.
- R4: A write holds mem_ce_n and mem_we_n low for exactly N_WP = max(ceil(100/T), ceil(60/T)) cycles. mem_oe_n stays 1 throughout.
- R5: mem_dq_oe is 1 from the cycle mem_we_n falls until one cycle after mem_we_n rises, and mem_ce_n stays low in that extra cycle. mem_dq_oe is 0 whenever mem_ce_n is 1.
- R6: After a write, mem_ce_n stays high for N_WREC = max(ceil(10/T), ceil(150/T) - N_WP - 1) cycles before req_ready returns. After a read, the gap is ceil(10/T) cycles.
- R7: req_ready is 0 from the cycle after an access is accepted until its recovery ends. A request offered while req_ready is 0 has no effect.
- R8: mem_oe_n and mem_we_n are never low together, and mem_we_n is low only while mem_ce_n is low.
- R9: The address and write data are registered when the request is accepted. mem_addr stays stable while mem_ce_n is low, and later changes on the host inputs do not reach the memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host offers an access |
| req_ready | output | 1 | Controller idle; request is taken on this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Byte address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | 8 | Read byte |
| mem_addr | output | 13 | Memory address lines |
| mem_dq_o | output | 8 | Data to memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_o (0 = bus released) |
| mem_dq_i | input | 8 | Data from memory |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |

## Verification
The bench's memory model returns a corrupted byte until the read window has lasted the full access time. A controller that captures one cycle early, or shortens the read window, therefore returns wrong data.

The bench measures the following at the ports:
- the write-pulse length;
- the hold cycle after write-enable rises;
- the recovery gap before ready returns.

An off-by-one in any count, or a bus released together with write-enable, is reported against the matching requirement.

While the controller is busy, the bench keeps offering a stray write and scrambles the host address and data. Reading back the target locations later exposes a design that accepts requests out of turn or passes host inputs straight to the memory.

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl #(
  parameter int CLK_NS   = 5,
  parameter int ADDR_W   = 13,
  parameter int DATA_W   = 8,
  parameter int T_ACC_NS = 150,
  parameter int T_CYC_NS = 150,
  parameter int T_WP_NS  = 100,
  parameter int T_DS_NS  = 60,
  parameter int T_WR_NS  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n
);

  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int N_RD   = max2(cyc(T_ACC_NS), cyc(T_CYC_NS));
  localparam int N_WP   = max2(cyc(T_WP_NS), cyc(T_DS_NS));
  localparam int N_WREC = max2(cyc(T_WR_NS), cyc(T_CYC_NS) - N_WP - 1);
  localparam int N_RREC = cyc(T_WR_NS);
  localparam int N_MAX  = max2(max2(N_RD, N_WP), max2(N_WREC, N_RREC));
  localparam int CNT_W  = $clog2(N_MAX + 1);

  typedef enum logic [2:0] {ST_IDLE, ST_RD, ST_WR, ST_WH, ST_REC} st_t;

  st_t               st;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              rsp_q;

  wire last = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      rsp_q   <= 1'b0;
    end else begin
      rsp_q <= 1'b0;
      case (st)
        ST_IDLE: if (req_valid) begin
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          st      <= req_write ? ST_WR : ST_RD;
          cnt     <= req_write ? CNT_W'(N_WP - 1) : CNT_W'(N_RD - 1);
        end
        ST_RD: if (last) begin
          rdata_q <= mem_dq_i;
          rsp_q   <= 1'b1;
          st      <= ST_REC;
          cnt     <= CNT_W'(N_RREC - 1);
        end else cnt <= cnt - 1'b1;
        ST_WR: if (last) st <= ST_WH;
               else cnt <= cnt - 1'b1;
        ST_WH: begin
          st  <= ST_REC;
          cnt <= CNT_W'(N_WREC - 1);
        end
        ST_REC: if (last) st <= ST_IDLE;
                else cnt <= cnt - 1'b1;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (st == ST_IDLE);
  assign rsp_valid = rsp_q;
  assign rsp_rdata = rdata_q;
  assign mem_addr  = addr_q;
  assign mem_dq_o  = wdata_q;
  assign mem_ce_n  = !(st == ST_RD || st == ST_WR || st == ST_WH);
  assign mem_we_n  = !(st == ST_WR);
  assign mem_oe_n  = !(st == ST_RD);
  assign mem_dq_oe = (st == ST_WR || st == ST_WH);

  a_r8_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));
  a_r8_we_inside_ce: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_ce_n);
  a_r9_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));
  a_r5_hold_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (!mem_ce_n && mem_dq_oe));
  a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ce_n) |-> !mem_dq_oe);
  a_r7_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |-> !req_ready);
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  a_r3_after_window: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> rsp_valid);

endmodule

// File: tb/sim_sram_seq_ctrl.sv
`timescale 1ns/1ps
module sim_sram_seq_ctrl;
  localparam int PER    = 5;
  localparam int N_RD   = (150 + PER - 1) / PER;
  localparam int N_WP   = ((100 + PER - 1) / PER > (60 + PER - 1) / PER) ?
                          (100 + PER - 1) / PER : (60 + PER - 1) / PER;
  localparam int N_RREC = (10 + PER - 1) / PER;
  localparam int N_WREC = (N_RREC > N_RD - N_WP - 1) ? N_RREC : N_RD - N_WP - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [12:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rsp_valid, mem_dq_oe, mem_ce_n, mem_we_n, mem_oe_n;
  logic [7:0]  rsp_rdata, mem_dq_o;
  logic [7:0]  mem_dq_i = '0;
  logic [12:0] mem_addr;

  always #2.5 clk = ~clk;

  sram_seq_ctrl #(.CLK_NS(PER)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n));

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [7:0] mem    [int];
  logic [7:0] shadow [int];

  function automatic logic [7:0] init_val(input logic [12:0] a);
    return a[7:0] ^ {3'b000, a[12:8]} ^ 8'h5A;
  endfunction
  function automatic logic [7:0] mem_val(input int a);
    return mem.exists(a) ? mem[a] : init_val(13'(a));
  endfunction
  function automatic logic [7:0] exp_val(input int a);
    return shadow.exists(a) ? shadow[a] : init_val(13'(a));
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // port monitor and memory model, evaluated away from the active edge
  bit prev_we = 1, prev_oe = 1, prev_rdy = 1, prev_rsp = 0, prev_ce = 1, last_wr = 0;
  int wlen = 0, rlen = 0, ce_hi = 0, acc = 0;
  always @(negedge clk) if (rst_n && !done) begin
    if (!mem_oe_n && !mem_we_n) chk(0, "R8 oe/we both low", 0, 1);
    if (!mem_we_n && mem_ce_n)  chk(0, "R8 we low without ce", 0, 1);
    if (mem_ce_n && mem_dq_oe)  chk(0, "R5 bus driven while deselected", 1, 0);
    if (!mem_ce_n && req_ready) chk(0, "R7 ready during access", 1, 0);
    if (prev_we && !mem_we_n) chk(mem_dq_oe, "R5 drive at write start", int'(mem_dq_oe), 1);
    if (!prev_we && mem_we_n) begin
      chk(wlen == N_WP, "R4 write pulse length", wlen, N_WP);
      chk(!mem_ce_n && mem_dq_oe, "R5 hold cycle after we rise",
          int'(mem_dq_oe) & int'(!mem_ce_n), 1);
      mem[int'(mem_addr)] = mem_dq_o;
    end
    if (!prev_oe && mem_oe_n) begin
      chk(rlen == N_RD, "R2 read window length", rlen, N_RD);
      chk(rsp_valid, "R3 response after window", int'(rsp_valid), 1);
    end
    if (rsp_valid && prev_rsp) chk(0, "R3 response longer than one cycle", 2, 1);
    if (req_ready && !prev_rdy)
      chk(ce_hi == (last_wr ? N_WREC : N_RREC), "R6 recovery gap", ce_hi,
          last_wr ? N_WREC : N_RREC);
    if (prev_ce && !mem_ce_n) last_wr = !mem_we_n;
    wlen  = mem_we_n ? 0 : wlen + 1;
    rlen  = mem_oe_n ? 0 : rlen + 1;
    ce_hi = mem_ce_n ? ce_hi + 1 : 0;
    acc   = (!mem_ce_n && !mem_oe_n) ? acc + 1 : 0;
    mem_dq_i <= (acc >= N_RD) ? mem_val(int'(mem_addr)) : ~mem_val(int'(mem_addr));
    prev_we = mem_we_n; prev_oe = mem_oe_n; prev_rdy = req_ready;
    prev_rsp = rsp_valid; prev_ce = mem_ce_n;
  end

  task automatic op(input bit wr, input logic [12:0] a, input logic [7:0] d, input bit junk);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    chk(!req_ready, "R7 ready drops after accept", int'(req_ready), 0);
    if (junk) begin
      // R7: stray write offered while busy must be ignored
      req_write = 1; req_addr = a ^ 13'h1555; req_wdata = ~d;
      repeat (3) @(negedge clk);
    end
    req_valid = 0;
    req_addr = ~a; req_wdata = d ^ 8'hA5;   // R9: host changes after accept
    if (wr) shadow[int'(a)] = d;
    else begin
      int k = 0;
      while (!rsp_valid && k < 200) begin @(negedge clk); k++; end
      chk(rsp_valid && rsp_rdata == exp_val(int'(a)), "R3 read data",
          int'(rsp_rdata), int'(exp_val(int'(a))));
    end
  endtask

  initial begin
    void'($urandom(32'h1A2B));
    repeat (3) @(negedge clk);
    chk(req_ready && mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && !rsp_valid,
        "R1 state in reset", int'({req_ready, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, rsp_valid}),
        int'(6'b111100));
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && !rsp_valid,
        "R1 state after reset", int'({req_ready, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, rsp_valid}),
        int'(6'b111100));
    // directed corners
    op(0, 13'h0000, 8'h00, 0);
    op(1, 13'h0000, 8'hFF, 1);
    op(0, 13'h0000, 8'h00, 0);
    op(0, 13'h1555, 8'h00, 0);          // R7: stray write target untouched
    op(1, 13'h1FFF, 8'h00, 0);
    op(0, 13'h1FFF, 8'h00, 1);
    op(0, 13'h0AAA, 8'h00, 0);          // stray target of the read above
    op(1, 13'h0123, 8'h3C, 0);
    op(1, 13'h0123, 8'hC3, 0);
    op(0, 13'h0123, 8'h00, 0);
    // constrained random mix over a small hot pool and the full range
    for (int i = 0; i < 250; i++) begin
      logic [12:0] a;
      a = ($urandom % 3 == 0) ? 13'($urandom % 16) : 13'($urandom);
      op(1'($urandom), a, 8'($urandom), ($urandom % 8) == 0);
    end
    for (int i = 0; i < 16; i++) op(0, 13'(i), 8'h00, 0);
    repeat (20) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule